// File: doc/BRIEF.md
# Trap and Interrupt Control Register Block

This block is the system-control register file that sits beside a processor pipeline and handles traps. Five request sources can enter in any cycle. Three are raised inside the core: an undefined operation, an arithmetic overflow and a system call. Two come from outside it: an external interrupt line and a built-in count/compare timer. When at least one request is live and not masked, the block raises a redirect in the same cycle and drives the handler address on the target output. At the next clock edge it records the following state:

- the program counter of the affected instruction;
- a cause code;
- an exception-level flag;
- for internal faults, the faulting memory address.

A return strobe sends the fetch stream back to the saved program counter and clears the exception level. Handler entry works in one of two ways. By default every trap goes to one fixed entry address. When vectored dispatch is enabled in the status register, each source has its own entry, and the entries are spaced 0x20 bytes apart. Software reads and writes the registers through an index-addressed port. The read path is combinational. A write takes effect at the clock edge while the write strobe is high.

Top module: `trap_ctrl_unit`

## Requirements
- R1: When a trap is taken, the saved-PC register (index 14) holds the value of `fault_pc` from that cycle after the clock edge.
- R2: When a trap is taken, the cause register (index 13) is loaded with the source code in bits 6:2, and all its other bits are zero. The codes are: undefined operation 10, overflow 12, system call 8, external interrupt 0, timer 7.
- R3: When status bit 1 is 0 (fixed dispatch), every taken trap drives `redirect_pc` to 0x80000180.
- R4: When status bit 1 is 1 (vectored dispatch), a taken trap drives `redirect_pc` to 0x80000000 + 0x20 × slot. The slots are: undefined operation 0, overflow 1, system call 2, external interrupt 3, timer 4.
- R5: When several sources request in the same cycle, the one taken is chosen in this priority order: undefined operation, then overflow, then system call, then external interrupt, then timer.
- R6: Status bit 0 (exception level) is set by a taken trap and cleared by a return. While it is set, external and timer requests are masked, and internal faults are still taken.
- R7: A return strobe with no trap in the same cycle raises `redirect` with `redirect_pc` equal to the saved PC. If a trap is taken in the same cycle, the trap wins.
- R8: The register map is as follows:
  - index 8: bad address, read only;
  - index 9: counter, writable;
  - index 11: compare, writable;
  - index 12: status, bits 1:0 writable;
  - index 13: cause, read only;
  - index 14: saved PC, writable;
  - every other index reads as zero.
- R9: The counter (index 9) increments by one every cycle. A write to it loads the written value instead.
- R10: A timer request becomes pending at the clock edge where the counter equals the compare value. A write to the compare register clears the pending request.
- R11: The bad-address register captures `fault_addr` only when an internal fault is taken. Interrupts leave it unchanged.
- R12: After reset, status, cause, saved PC, bad address and counter are all 0, compare is 0xFFFFFFFF, and `redirect` is low.
- R13: `redirect` and `redirect_pc` respond in the same cycle as the request. The register updates become visible after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_undef | input | 1 | Undefined operation fault request |
| req_ovf | input | 1 | Arithmetic overflow fault request |
| req_sys | input | 1 | System call request |
| irq_ext | input | 1 | External interrupt level |
| fault_pc | input | 32 | PC of the faulting or interrupted instruction |
| fault_addr | input | 32 | Faulting memory address |
| eret | input | 1 | Return-from-trap strobe |
| reg_idx | input | 5 | Register index for the access port |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| redirect | output | 1 | Fetch redirect request |
| redirect_pc | output | 32 | Fetch redirect target |

## Verification
The bound checker watches every cycle for the following:
- the saved-PC capture and the setting of the exception level on every taken trap;
- the clearing of the exception level on a return;
- the masking of interrupts while the exception level is set;
- a return target that always equals the saved PC;
- handler targets that always fall on a legal entry;
- the top priority of the undefined-operation fault;
- a counter that advances by one unless it is written.

Some behaviours only the bench scenarios can show. The bench sweeps every combination of the four directly driven sources in both dispatch modes, which shows the full priority order, the exact vectored and fixed addresses, and the cause codes. Timed scenarios show the cycle in which the timer match fires, the clearing of the pending timer request by a compare write, a trap winning over a return in the same cycle, and the read-only registers.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned N_SRC      = 5;
  localparam int unsigned SLOT_W     = $clog2(N_SRC);
  localparam int unsigned CODE_W     = 5;
  localparam int unsigned CODE_LSB   = 2;
  localparam int unsigned N_INTERNAL = 3;

  localparam int unsigned IDX_BADADDR = 8;
  localparam int unsigned IDX_COUNT   = 9;
  localparam int unsigned IDX_COMPARE = 11;
  localparam int unsigned IDX_STATUS  = 12;
  localparam int unsigned IDX_CAUSE   = 13;
  localparam int unsigned IDX_EPC     = 14;

  typedef enum logic [SLOT_W-1:0] {
    SRC_UNDEF = 3'd0,
    SRC_OVF   = 3'd1,
    SRC_SYS   = 3'd2,
    SRC_EXT   = 3'd3,
    SRC_TMR   = 3'd4
  } src_e;

  function automatic logic [CODE_W-1:0] cause_code(input logic [SLOT_W-1:0] s);
    case (src_e'(s))
      SRC_UNDEF: cause_code = 5'd10;
      SRC_OVF:   cause_code = 5'd12;
      SRC_SYS:   cause_code = 5'd8;
      SRC_EXT:   cause_code = 5'd0;
      default:   cause_code = 5'd7;
    endcase
  endfunction

  function automatic logic is_internal(input logic [SLOT_W-1:0] s);
    return 32'(s) < N_INTERNAL;
  endfunction
endpackage

// File: rtl/trap_prio.sv
module trap_prio #(
  parameter int unsigned N  = 5,
  parameter int unsigned SW = 3
) (
  input  logic [N-1:0]  req,
  output logic          take,
  output logic [SW-1:0] slot
);
  function automatic logic [SW-1:0] first_index(input logic [N-1:0] v);
    logic [SW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = SW'(i);
    end
    return r;
  endfunction

  always_comb begin
    take = |req;
    slot = first_index(req);
  end
endmodule

// File: rtl/trap_timer.sv
module trap_timer #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_wr,
  input  logic         cmp_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cmp_q,
  output logic         pend_q
);
  logic match;
  assign match = (cnt_q == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmp_q  <= '1;
      pend_q <= 1'b0;
    end else begin
      cnt_q <= cnt_wr ? wdata : cnt_q + W'(1);
      if (cmp_wr) cmp_q <= wdata;
      if (cmp_wr)     pend_q <= 1'b0;
      else if (match) pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
  parameter int unsigned W         = 32,
  parameter int unsigned SW        = 3,
  parameter logic [W-1:0] BASE      = 32'h8000_0000,
  parameter logic [W-1:0] FIXED_OFF = 32'h0000_0180,
  parameter int unsigned STRIDE_LG = 5
) (
  input  logic          vec_en,
  input  logic [SW-1:0] slot,
  output logic [W-1:0]  target
);
  function automatic logic [W-1:0] entry_of(input logic [SW-1:0] s);
    return BASE + (W'(s) << STRIDE_LG);
  endfunction

  always_comb begin
    target = vec_en ? entry_of(slot) : (BASE + FIXED_OFF);
  end
endmodule

// File: rtl/trap_ctrl_unit.sv
module trap_ctrl_unit #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned IDX_W     = 5,
  parameter logic [XLEN-1:0] BASE      = 32'h8000_0000,
  parameter logic [XLEN-1:0] FIXED_OFF = 32'h0000_0180,
  parameter int unsigned STRIDE_LG = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_undef,
  input  logic            req_ovf,
  input  logic            req_sys,
  input  logic            irq_ext,
  input  logic [XLEN-1:0] fault_pc,
  input  logic [XLEN-1:0] fault_addr,
  input  logic            eret,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic            reg_wr,
  input  logic [XLEN-1:0] reg_wdata,
  output logic [XLEN-1:0] reg_rdata,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc
);
  import trap_pkg::*;

  localparam int unsigned PAD_W = XLEN - CODE_W - CODE_LSB;

  logic [XLEN-1:0]   epc_q, cause_q, badaddr_q;
  logic              exl_q, vec_q;
  logic [XLEN-1:0]   cnt_q, cmp_q;
  logic              tmr_pend;
  logic [N_SRC-1:0]  req_vec;
  logic              take_evt, eret_evt;
  logic [SLOT_W-1:0] take_slot;
  logic [XLEN-1:0]   vec_target;
  logic              cnt_wr, cmp_wr, status_wr, epc_wr;

  assign cnt_wr    = reg_wr && (reg_idx == IDX_W'(IDX_COUNT));
  assign cmp_wr    = reg_wr && (reg_idx == IDX_W'(IDX_COMPARE));
  assign status_wr = reg_wr && (reg_idx == IDX_W'(IDX_STATUS));
  assign epc_wr    = reg_wr && (reg_idx == IDX_W'(IDX_EPC));

  // Slot order is the priority order: lowest index wins.
  assign req_vec[SRC_UNDEF] = req_undef;
  assign req_vec[SRC_OVF]   = req_ovf;
  assign req_vec[SRC_SYS]   = req_sys;
  assign req_vec[SRC_EXT]   = irq_ext  & ~exl_q;
  assign req_vec[SRC_TMR]   = tmr_pend & ~exl_q;

  trap_prio #(.N(N_SRC), .SW(SLOT_W)) u_prio (
    .req  (req_vec),
    .take (take_evt),
    .slot (take_slot)
  );

  trap_timer #(.W(XLEN)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_wr (cnt_wr),
    .cmp_wr (cmp_wr),
    .wdata  (reg_wdata),
    .cnt_q  (cnt_q),
    .cmp_q  (cmp_q),
    .pend_q (tmr_pend)
  );

  trap_vector #(
    .W(XLEN), .SW(SLOT_W), .BASE(BASE), .FIXED_OFF(FIXED_OFF), .STRIDE_LG(STRIDE_LG)
  ) u_vector (
    .vec_en (vec_q),
    .slot   (take_slot),
    .target (vec_target)
  );

  assign eret_evt    = eret & ~take_evt;
  assign redirect    = take_evt | eret_evt;
  assign redirect_pc = take_evt ? vec_target : epc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q     <= '0;
      cause_q   <= '0;
      badaddr_q <= '0;
      exl_q     <= 1'b0;
      vec_q     <= 1'b0;
    end else begin
      if (take_evt)    epc_q <= fault_pc;
      else if (epc_wr) epc_q <= reg_wdata;

      if (take_evt) cause_q <= {{PAD_W{1'b0}}, cause_code(take_slot), {CODE_LSB{1'b0}}};

      if (take_evt && is_internal(take_slot)) badaddr_q <= fault_addr;

      if (take_evt)       exl_q <= 1'b1;
      else if (eret_evt)  exl_q <= 1'b0;
      else if (status_wr) exl_q <= reg_wdata[0];

      if (status_wr) vec_q <= reg_wdata[1];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (32'(reg_idx))
      IDX_BADADDR: reg_rdata = badaddr_q;
      IDX_COUNT:   reg_rdata = cnt_q;
      IDX_COMPARE: reg_rdata = cmp_q;
      IDX_STATUS:  reg_rdata = {{(XLEN-2){1'b0}}, vec_q, exl_q};
      IDX_CAUSE:   reg_rdata = cause_q;
      IDX_EPC:     reg_rdata = epc_q;
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_undef,
  input logic         req_ovf,
  input logic         req_sys,
  input logic         eret,
  input logic         redirect,
  input logic [W-1:0] redirect_pc,
  input logic         take_evt,
  input logic         eret_evt,
  input logic         exl_q,
  input logic [W-1:0] epc_q,
  input logic [W-1:0] fault_pc,
  input logic [W-1:0] cause_q,
  input logic [W-1:0] cnt_q,
  input logic         cnt_wr
);
  p_epc_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |=> epc_q == $past(fault_pc));

  p_exl_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |=> exl_q);

  p_exl_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eret_evt |=> !exl_q);

  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exl_q && !req_undef && !req_ovf && !req_sys && !eret) |-> !redirect);

  p_eret_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eret_evt |-> (redirect && redirect_pc == epc_q));

  p_legal_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |-> (redirect_pc == 32'h8000_0180 ||
                  (redirect_pc[W-1:8] == 24'h80_0000 && redirect_pc[4:0] == 5'd0)));

  p_undef_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_undef |=> cause_q[6:2] == 5'd10);

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> cnt_q == $past(cnt_q) + 32'd1);
endmodule

bind trap_ctrl_unit trap_ctrl_chk #(.W(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_undef   (req_undef),
  .req_ovf     (req_ovf),
  .req_sys     (req_sys),
  .eret        (eret),
  .redirect    (redirect),
  .redirect_pc (redirect_pc),
  .take_evt    (take_evt),
  .eret_evt    (eret_evt),
  .exl_q       (exl_q),
  .epc_q       (epc_q),
  .fault_pc    (fault_pc),
  .cause_q     (cause_q),
  .cnt_q       (cnt_q),
  .cnt_wr      (cnt_wr)
);

// File: tb/trap_ctrl_unit_tb.sv
module trap_ctrl_unit_tb_top;
  localparam int CLK_PERIOD = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_undef, req_ovf, req_sys, irq_ext, eret, reg_wr;
  logic [31:0] fault_pc, fault_addr, reg_wdata, reg_rdata, redirect_pc;
  logic [4:0]  reg_idx;
  logic        redirect;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_ctrl_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_undef(req_undef), .req_ovf(req_ovf),
    .req_sys(req_sys), .irq_ext(irq_ext), .fault_pc(fault_pc),
    .fault_addr(fault_addr), .eret(eret), .reg_idx(reg_idx), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .redirect(redirect),
    .redirect_pc(redirect_pc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    reg_idx = 5'(idx);
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    reg_idx = 5'(idx); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [31:0] exp_target(input bit vec, input int slot);
    return vec ? 32'h8000_0000 + 32'(slot) * 32 : 32'h8000_0180;
  endfunction

  function automatic logic [31:0] exp_cause(input int slot);
    int c;
    case (slot)
      0: c = 10; 1: c = 12; 2: c = 8; 3: c = 0; default: c = 7;
    endcase
    return 32'(c) * 4;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, bad_exp, pc_exp;
    int slot, wait_n;
    rst_n = 1'b0; req_undef = 0; req_ovf = 0; req_sys = 0; irq_ext = 0; eret = 0;
    reg_wr = 0; reg_idx = '0; reg_wdata = '0; fault_pc = '0; fault_addr = '0;
    bad_exp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R12 reset state
    chk("R12 redirect", {31'd0, redirect}, 32'd0);
    rd(12, v); chk("R12 status", v, 32'd0);
    rd(13, v); chk("R12 cause", v, 32'd0);
    rd(14, v); chk("R12 epc", v, 32'd0);
    rd(8, v);  chk("R12 badaddr", v, 32'd0);
    rd(11, v); chk("R12 compare", v, 32'hFFFF_FFFF);
    rd(10, v); chk("R8 unmapped index reads zero", v, 32'd0);

    // Sweep of all direct source combinations in both dispatch modes (R1..R5, R11, R13)
    for (int vec = 0; vec < 2; vec++) begin
      @(negedge clk);
      wr(12, 32'(vec) << 1);
      for (int m = 1; m < 16; m++) begin
        slot = 0;
        for (int b = 3; b >= 0; b--) if (m[b]) slot = b;
        req_undef = m[0]; req_ovf = m[1]; req_sys = m[2]; irq_ext = m[3];
        fault_pc = 32'h1000 + 32'(m) * 4 + 32'(vec) * 32'h100;
        fault_addr = 32'h5000 + 32'(m);
        #1;
        chk("R13 redirect same cycle", {31'd0, redirect}, 32'd1);
        chk(vec ? "R4 R5 vectored target" : "R3 R5 fixed target", redirect_pc, exp_target(vec[0], slot));
        @(negedge clk);
        req_undef = 0; req_ovf = 0; req_sys = 0; irq_ext = 0;
        if (slot < 3) bad_exp = fault_addr;
        rd(13, v); chk("R2 R5 cause code", v, exp_cause(slot));
        rd(14, v); chk("R1 saved pc", v, fault_pc);
        rd(12, v); chk("R6 exl set", v, (32'(vec) << 1) | 32'd1);
        rd(8, v);  chk("R11 bad address", v, bad_exp);
        @(negedge clk);
        irq_ext = 1'b1; #1;
        chk("R6 external masked", {31'd0, redirect}, 32'd0);
        irq_ext = 1'b0;
        @(negedge clk);
        eret = 1'b1; #1;
        chk("R7 return redirect", {31'd0, redirect}, 32'd1);
        chk("R7 return target", redirect_pc, fault_pc);
        @(negedge clk);
        eret = 1'b0;
        rd(12, v); chk("R6 exl cleared", v, 32'(vec) << 1);
      end
    end
    // vectored mode is active now

    // R9 counter load and step
    wr(9, 32'd100);
    rd(9, v); chk("R9 counter loaded", v, 32'd100);
    @(negedge clk);
    rd(9, v); chk("R9 counter step", v, 32'd101);

    // R10 timer match timing
    wr(9, 32'd0);
    wr(11, 32'd20);
    fault_pc = 32'h2222_0000;
    wait_n = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk); #1;
      if (redirect) begin wait_n = i; break; end
    end
    chk("R10 timer fires on match cycle", 32'(wait_n), 32'd20);
    chk("R4 timer vectored target", redirect_pc, 32'h8000_0080);
    @(negedge clk);
    rd(13, v); chk("R2 timer cause", v, 32'd28);
    rd(14, v); chk("R1 timer saved pc", v, 32'h2222_0000);
    rd(8, v);  chk("R11 interrupt keeps bad address", v, bad_exp);
    // R6 internal fault taken while exception level set
    req_sys = 1'b1; #1;
    chk("R6 internal taken at exl", {31'd0, redirect}, 32'd1);
    chk("R6 R4 syscall target", redirect_pc, 32'h8000_0040);
    req_sys = 1'b0;
    @(negedge clk);
    wr(11, 32'hFFFF_FFFF);
    eret = 1'b1; #1;
    chk("R7 return after timer", redirect_pc, 32'h2222_0000);
    @(negedge clk);
    eret = 1'b0; #1;
    chk("R10 compare write cleared pending", {31'd0, redirect}, 32'd0);

    // R7 trap wins over return in the same cycle
    eret = 1'b1; req_ovf = 1'b1; fault_pc = 32'h3330; #1;
    chk("R7 trap beats return", redirect_pc, 32'h8000_0020);
    @(negedge clk);
    eret = 1'b0; req_ovf = 1'b0;
    rd(14, v); chk("R7 R1 saved pc from trap", v, 32'h3330);

    // R8 writable saved PC, read-only cause and bad address
    wr(14, 32'h0000_4440);
    eret = 1'b1; #1;
    chk("R8 written saved pc used by return", redirect_pc, 32'h0000_4440);
    @(negedge clk);
    eret = 1'b0;
    wr(13, 32'h0000_FFFF);
    rd(13, v); chk("R8 cause read only", v, 32'd48);
    wr(8, 32'hDEAD_0000);
    rd(8, v); chk("R8 bad address read only", v, bad_exp);
    wr(11, 32'h1234_5678);
    rd(11, v); chk("R8 compare writable", v, 32'h1234_5678);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule